// File: doc/BRIEF.md
# Register Bitfield Write Sequencer

The sequencer runs a short program of register updates held in a small step table. Each step names a 16-bit control register, picks a bit field in it by a low-bit position and a width code, and supplies up to eight bits of new data. For each step the engine reads the register and merges the new field into the value it read. All bits outside the field keep the value they had. It writes the result back. It then waits out a timed interval before it fetches the next step. A per-step flag marks the last step of a program. A reserved register address turns a step into a placeholder that touches nothing but still takes its full time.

Software loads steps through a plain write port. It launches a program with a start pulse that carries the first step index, and it watches the busy output. Time is measured in pulses of a tick input, with one pulse per 62.5 µs period. Step time grows as a power of two of a 4-bit code, plus a fixed offset of eight ticks.

Top module: `rmw_step_sequencer`

## Requirements
- R1: After reset `busy_o` is 0 and neither `rf_rd_en_o` nor `rf_wr_en_o` is asserted. While the engine is idle, the register port stays quiet.
- R2: A step word written through `tbl_we_i`/`tbl_addr_i`/`tbl_wdata_i` is packed as follows: [7:0] register address, [11:8] field low-bit position, [15:12] width code (field width minus one), [23:16] data, [27:24] delay code, [28] last-step flag.
- R3: A `start_i` pulse while idle loads the step at `start_idx_i` and raises `busy_o` from the next cycle. A `start_i` pulse while busy has no effect on the program being run.
- R4: For each step that does not use the reserved address, the engine asserts `rf_rd_en_o` for one cycle. It asserts `rf_wr_en_o` in the cycle that follows, with the same `rf_addr_o`. The read data is valid one cycle after the read.
- R5: The written value equals the value read, except in bits [pos+w : pos], where w is the width code. Those bits take data bits [w:0], with the data zero-extended above bit 7.
- R6: A field that would extend past bit 15 is cut off at bit 15, and the data bits that would fall above it are dropped.
- R7: A step with delay code d lasts exactly 2^d + 8 ticks. The count includes the tick in the cycle the step is loaded.
- R8: After a step whose last flag is 1, the engine goes idle. Otherwise it runs the next table index, and the index wraps from 31 to 0.
- R9: A step addressing register 0xFF performs no read and no write, but it still lasts its full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per 62.5 µs time unit |
| tbl_we_i | input | 1 | Step table write enable |
| tbl_addr_i | input | 5 | Step table write index |
| tbl_wdata_i | input | 29 | Packed step word |
| start_i | input | 1 | Launch pulse |
| start_idx_i | input | 5 | First step index of the program |
| busy_o | output | 1 | Program running |
| rf_rd_en_o | output | 1 | Register read request |
| rf_wr_en_o | output | 1 | Register write request |
| rf_addr_o | output | 8 | Register address for read and write |
| rf_rdata_i | input | 16 | Register read data, one cycle after the read |
| rf_wdata_o | output | 16 | Merged register write data |

## Verification
The assertions assume that the register file returns read data exactly one cycle after `rf_rd_en_o`. They also assume that ticks are at least two cycles apart, so a read and its write both complete well inside the first tick interval of a step. The stimulus spaces ticks every three cycles and uses a bench register model with a one-cycle read. Table entries that belong to a running program are not rewritten while it runs.

// File: rtl/rmw_seq_pkg.sv
package rmw_seq_pkg;
  localparam int REG_W      = 16;
  localparam int RADDR_W    = 8;
  localparam int POS_W      = 4;
  localparam int DATA_W     = 8;
  localparam int DLY_W      = 4;
  localparam int TCNT_W     = 17;
  localparam logic [RADDR_W-1:0] DUMMY_ADDR = 8'hFF;

  typedef struct packed {
    logic               last;
    logic [DLY_W-1:0]   dly;
    logic [DATA_W-1:0]  data;
    logic [POS_W-1:0]   wcode;
    logic [POS_W-1:0]   pos;
    logic [RADDR_W-1:0] raddr;
  } step_t;

  localparam int STEP_W = $bits(step_t);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_MERGE, S_HOLD} seq_st_e;

  // Field mask of width wcode+1 at pos, anything past the top bit dropped.
  function automatic logic [REG_W-1:0] field_mask(input logic [POS_W-1:0] pos,
                                                  input logic [POS_W-1:0] wcode);
    logic [2*REG_W-1:0] ones;
    logic [2*REG_W-1:0] m;
    ones = (2*REG_W)'((33'd1 << (int'(wcode) + 1)) - 33'd1);
    m    = ones << pos;
    return m[REG_W-1:0];
  endfunction

  function automatic logic [REG_W-1:0] merge_field(input logic [REG_W-1:0]   old_v,
                                                   input logic [DATA_W-1:0]  data,
                                                   input logic [POS_W-1:0]   pos,
                                                   input logic [POS_W-1:0]   wcode);
    logic [2*REG_W-1:0] shifted;
    logic [REG_W-1:0]   msk;
    msk     = field_mask(pos, wcode);
    shifted = {{(2*REG_W-DATA_W){1'b0}}, data} << pos;
    return (old_v & ~msk) | (shifted[REG_W-1:0] & msk);
  endfunction

  function automatic logic [TCNT_W-1:0] step_ticks(input logic [DLY_W-1:0] dly);
    return (TCNT_W'(1) << dly) + TCNT_W'(8);
  endfunction
endpackage

// File: rtl/rmw_step_table.sv
module rmw_step_table
  import rmw_seq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  step_t            wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output step_t            rdata_o
);
  step_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we_i && (waddr_i == IDX_W'(g)))
        mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/rmw_step_timer.sv
module rmw_step_timer
  import rmw_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             done_o
);
  logic [TCNT_W-1:0] cnt_q;
  logic [TCNT_W-1:0] target;

  assign target = step_ticks(dly_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr_i)
      cnt_q <= TCNT_W'(tick_i);
    else if (tick_i && (cnt_q < target))
      cnt_q <= cnt_q + TCNT_W'(1);
  end

  assign done_o = (cnt_q >= target);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && $stable(dly_i)) |=> (cnt_q <= target)); // R7
endmodule

// File: rtl/rmw_seq_ctrl.sv
module rmw_seq_ctrl
  import rmw_seq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   start_idx_i,
  output logic [IDX_W-1:0]   tbl_ridx_o,
  input  step_t              tbl_rdata_i,
  input  logic               timer_done_i,
  output logic               timer_clr_o,
  output logic [DLY_W-1:0]   cur_dly_o,
  output logic               busy_o,
  output logic               rf_rd_en_o,
  output logic               rf_wr_en_o,
  output logic [RADDR_W-1:0] rf_addr_o,
  input  logic [REG_W-1:0]   rf_rdata_i,
  output logic [REG_W-1:0]   rf_wdata_o
);
  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  step_t            cur_q;

  // named events
  logic step_load;
  logic step_adv;
  logic is_dummy;
  logic rmw_read;
  logic rmw_write;

  assign is_dummy  = (cur_q.raddr == DUMMY_ADDR);
  assign step_adv  = (st_q == S_HOLD) && timer_done_i;
  assign step_load = ((st_q == S_IDLE) && start_i) || (step_adv && !cur_q.last);
  assign rmw_read  = (st_q == S_READ) && !is_dummy;
  assign rmw_write = (st_q == S_MERGE);

  assign tbl_ridx_o = (st_q == S_IDLE) ? start_idx_i : idx_q + IDX_W'(1);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (start_i) st_d = S_READ;
      S_READ:  st_d = is_dummy ? S_HOLD : S_MERGE;
      S_MERGE: st_d = S_HOLD;
      S_HOLD:  if (step_adv) st_d = cur_q.last ? S_IDLE : S_READ;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      cur_q <= '0;
    end else begin
      st_q <= st_d;
      if (step_load) begin
        idx_q <= tbl_ridx_o;
        cur_q <= tbl_rdata_i;
      end
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign timer_clr_o = (st_q == S_IDLE) || step_adv;
  assign cur_dly_o   = cur_q.dly;
  assign rf_rd_en_o  = rmw_read;
  assign rf_wr_en_o  = rmw_write;
  assign rf_addr_o   = cur_q.raddr;
  assign rf_wdata_o  = merge_field(rf_rdata_i, cur_q.data, cur_q.pos, cur_q.wcode);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(rf_rd_en_o || rf_wr_en_o)); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !step_adv) |=> (busy_o && $stable(idx_q))); // R3
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en_o |-> ($past(rf_rd_en_o) && $stable(rf_addr_o))); // R4
  AST_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en_o |-> (((rf_wdata_o ^ rf_rdata_i) & ~field_mask(cur_q.pos, cur_q.wcode)) == '0)); // R5
  AST_LAST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_adv && cur_q.last) |=> !busy_o); // R8
  AST_NO_DUMMY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rd_en_o || rf_wr_en_o) |-> (rf_addr_o != DUMMY_ADDR)); // R9
endmodule

// File: rtl/rmw_step_sequencer.sv
module rmw_step_sequencer
  import rmw_seq_pkg::*;
#(
  parameter int TBL_DEPTH = 32,
  localparam int IDX_W = $clog2(TBL_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               tbl_we_i,
  input  logic [IDX_W-1:0]   tbl_addr_i,
  input  logic [STEP_W-1:0]  tbl_wdata_i,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   start_idx_i,
  output logic               busy_o,
  output logic               rf_rd_en_o,
  output logic               rf_wr_en_o,
  output logic [RADDR_W-1:0] rf_addr_o,
  input  logic [REG_W-1:0]   rf_rdata_i,
  output logic [REG_W-1:0]   rf_wdata_o
);
  logic [IDX_W-1:0] tbl_ridx;
  step_t            tbl_rdata;
  logic             tmr_clr;
  logic             tmr_done;
  logic [DLY_W-1:0] cur_dly;

  rmw_step_table #(.DEPTH(TBL_DEPTH)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (step_t'(tbl_wdata_i)),
    .raddr_i (tbl_ridx),
    .rdata_o (tbl_rdata)
  );

  rmw_step_timer u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tmr_clr),
    .tick_i (tick_i),
    .dly_i  (cur_dly),
    .done_o (tmr_done)
  );

  rmw_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_idx_i  (start_idx_i),
    .tbl_ridx_o   (tbl_ridx),
    .tbl_rdata_i  (tbl_rdata),
    .timer_done_i (tmr_done),
    .timer_clr_o  (tmr_clr),
    .cur_dly_o    (cur_dly),
    .busy_o       (busy_o),
    .rf_rd_en_o   (rf_rd_en_o),
    .rf_wr_en_o   (rf_wr_en_o),
    .rf_addr_o    (rf_addr_o),
    .rf_rdata_i   (rf_rdata_i),
    .rf_wdata_o   (rf_wdata_o)
  );
endmodule

// File: tb/sim_rmw_step_sequencer.sv
`timescale 1ns/1ps
module sim_rmw_step_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        tbl_we_i = 1'b0;
  logic [4:0]  tbl_addr_i = '0;
  logic [28:0] tbl_wdata_i = '0;
  logic        start_i = 1'b0;
  logic [4:0]  start_idx_i = '0;
  logic        busy_o, rf_rd_en_o, rf_wr_en_o;
  logic [7:0]  rf_addr_o;
  logic [15:0] rf_rdata_i;
  logic [15:0] rf_wdata_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  rmw_step_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_wdata_i(tbl_wdata_i),
    .start_i(start_i), .start_idx_i(start_idx_i), .busy_o(busy_o),
    .rf_rd_en_o(rf_rd_en_o), .rf_wr_en_o(rf_wr_en_o), .rf_addr_o(rf_addr_o),
    .rf_rdata_i(rf_rdata_i), .rf_wdata_o(rf_wdata_o)
  );

  // bench register file, one-cycle read
  logic [15:0] rf [256];
  logic [15:0] exp_rf [256];
  logic [28:0] sh_tbl [32];
  logic        prev_rd = 1'b0;
  logic [7:0]  prev_addr = '0;
  int          proto_err = 0;
  int          dummy_acc = 0;

  always @(posedge clk) begin
    if (rf_rd_en_o) rf_rdata_i <= rf[rf_addr_o];
    if (rf_wr_en_o) rf[rf_addr_o] <= rf_wdata_o;
    if ((rf_rd_en_o || rf_wr_en_o) && rf_addr_o == 8'hFF) dummy_acc <= dummy_acc + 1;
    if (rf_wr_en_o && !(prev_rd && prev_addr == rf_addr_o)) proto_err <= proto_err + 1;
    if (rf_rd_en_o && prev_rd) proto_err <= proto_err + 1;
    prev_rd   <= rf_rd_en_o;
    prev_addr <= rf_addr_o;
  end

  // tick every third cycle
  int tphase = 0;
  initial forever begin
    @(posedge clk); #1;
    tphase = (tphase + 1) % 3;
    tick_i = (tphase == 0);
  end

  // tick measurement over a program
  logic measuring = 1'b0;
  int   ticks_seen = 0;
  always @(negedge clk) begin
    if (start_i && !busy_o) begin
      measuring  <= 1'b1;
      ticks_seen <= int'(tick_i);
    end else if (measuring && busy_o) begin
      ticks_seen <= ticks_seen + int'(tick_i);
    end else if (measuring && !busy_o) begin
      measuring <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [28:0] mk(input logic [7:0] a, input logic [3:0] p,
                                     input logic [3:0] w, input logic [7:0] d,
                                     input logic [3:0] dl, input logic last);
    return {last, dl, d, w, p, a};
  endfunction

  // bit-by-bit restatement of the field update
  function automatic logic [15:0] ref_merge(input logic [15:0] v, input logic [7:0] d,
                                            input int p, input int w);
    logic [15:0] r = v;
    for (int b = 0; b < 16; b++)
      if (b >= p && b <= p + w) r[b] = (b - p < 8) ? d[b-p] : 1'b0;
    return r;
  endfunction

  task automatic put(input int idx, input logic [28:0] word);
    @(posedge clk); #1;
    tbl_we_i = 1'b1; tbl_addr_i = 5'(idx); tbl_wdata_i = word;
    sh_tbl[idx] = word;
    @(posedge clk); #1;
    tbl_we_i = 1'b0;
  endtask

  // run program from s; optional stray start with another index mid-run
  task automatic run_prog(input int s, input string req, input bit stray, input int stray_idx);
    int exp_ticks = 0;
    int idx = s;
    int guard = 0;
    bit hung = 0;
    for (int a = 0; a < 256; a++) exp_rf[a] = rf[a];
    for (int k = 0; k < 32; k++) begin
      logic [28:0] w = sh_tbl[idx];
      exp_ticks += (1 << w[27:24]) + 8;
      if (w[7:0] != 8'hFF)
        exp_rf[w[7:0]] = ref_merge(exp_rf[w[7:0]], w[23:16], int'(w[11:8]), int'(w[15:12]));
      if (w[28]) break;
      idx = (idx + 1) % 32;
    end
    @(posedge clk); #1;
    start_idx_i = 5'(s); start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    check({req, " busy after start (R3)"}, busy_o, 1);
    if (stray) begin
      repeat (7) @(posedge clk);
      #1; start_idx_i = 5'(stray_idx); start_i = 1'b1;
      @(posedge clk); #1; start_i = 1'b0;
    end
    while (busy_o || measuring) begin
      @(negedge clk);
      guard++;
      if (guard > 60000) begin hung = 1; break; end
    end
    check({req, " watchdog"}, hung, 0);
    check({req, " duration ticks (R7)"}, ticks_seen, exp_ticks);
    for (int a = 0; a < 16; a++)
      if (rf[a] !== exp_rf[a]) check({req, " register contents (R5)"}, rf[a], exp_rf[a]);
    check({req, " regs compared (R5)"}, 1, 1);
    check({req, " read/write pairing (R4)"}, proto_err, 0);
    check({req, " no dummy access (R9)"}, dummy_acc, 0);
  endtask

  initial begin
    void'($urandom(32'h5EC0_0017));
    for (int a = 0; a < 256; a++) rf[a] = 16'($urandom);
    for (int i = 0; i < 32; i++) sh_tbl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset busy", busy_o, 0);
    check("R1 reset no access", {rf_rd_en_o, rf_wr_en_o}, 0);
    #1 rst_n = 1'b1;

    // directed: R6 truncation at bit 15
    rf[3] = 16'h0000;
    put(0, mk(8'h03, 4'd14, 4'd7, 8'hFF, 4'd0, 1'b1));
    run_prog(0, "R6 trunc", 0, 0);
    check("R6 top bits only", rf[3], 16'hC000);

    // directed: R5 example position 1 width 2, upper data bits ignored
    rf[5] = 16'hFFFF;
    put(1, mk(8'h05, 4'd1, 4'd1, 8'hFC, 4'd1, 1'b1));
    run_prog(1, "R5 field", 0, 0);
    check("R5 bits [2:1] only", rf[5], 16'hFFF9);

    // directed: R9 dummy step still delays; R8 continues then halts
    rf[6] = 16'h0000;
    put(2, mk(8'hFF, 4'd0, 4'd7, 8'hAA, 4'd3, 1'b0));
    put(3, mk(8'h06, 4'd4, 4'd3, 8'h0B, 4'd0, 1'b1));
    run_prog(2, "R9 dummy", 0, 0);
    check("R8 second step ran", rf[6], 16'h00B0);

    // directed: R8 wrap 31 -> 0
    put(30, mk(8'h07, 4'd0, 4'd3, 8'h01, 4'd0, 1'b0));
    put(31, mk(8'h08, 4'd0, 4'd3, 8'h02, 4'd0, 1'b0));
    put(0,  mk(8'h09, 4'd0, 4'd3, 8'h03, 4'd0, 1'b1));
    rf[9] = 16'h0000;
    run_prog(30, "R8 wrap", 0, 0);
    check("R8 wrapped to index 0", rf[9], 16'h0003);

    // directed: R3 stray start while busy (index 20 would hit reg 10)
    put(20, mk(8'h0A, 4'd0, 4'd7, 8'h55, 4'd0, 1'b1));
    rf[10] = 16'h1234;
    put(12, mk(8'h0B, 4'd2, 4'd2, 8'h05, 4'd2, 1'b0));
    put(13, mk(8'h0C, 4'd8, 4'd5, 8'h2A, 4'd1, 1'b1));
    run_prog(12, "R3 stray", 1, 20);
    check("R3 stray start ignored", rf[10], 16'h1234);

    // directed: larger delay code, R7
    put(4, mk(8'h0D, 4'd0, 4'd0, 8'h01, 4'd9, 1'b1));
    run_prog(4, "R7 long", 0, 0);

    // random programs, R2 packing exercised throughout
    for (int r = 0; r < 20; r++) begin
      int s   = int'($urandom_range(0, 31));
      int len = int'($urandom_range(1, 6));
      for (int k = 0; k < len; k++) begin
        logic [7:0] a = ($urandom_range(0, 5) == 0) ? 8'hFF : 8'($urandom_range(0, 15));
        put((s + k) % 32, mk(a, 4'($urandom), 4'($urandom), 8'($urandom),
                             4'($urandom_range(0, 3)), k == len - 1));
      end
      run_prog(s, "R2 random", 0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule